// File: doc/BRIEF.md
# PLL Event Interrupt Status Block

This block sits between a PLL control module and its PLL and turns the traffic between them into software-visible status and a single interrupt line. Two PLL health indications (whether the PLL is locked, and whether it needs recalibration) appear as live bits in a 32-bit status word. Three control events get their own sticky flag in the same word: a lock request, an unlock request and a recalibration request sent to the PLL.

Each sticky flag is cleared by writing a 1 to its position, and writing 0 leaves it alone. A separate enable word, with the same bit layout, chooses which flags drive the combined interrupt output. Request inputs are edge-detected, so a request held high produces only one event.

The status and enable words are written through a single write port. `wr_sel_i` chooses the target: 0 for the status word and 1 for the enable word.

Top module: `pll_evt_irq`

## Requirements
- R1: Status bit 1 shows the value `lock_state_i` had at the previous rising clock edge.
- R2: Status bit 2 shows the value `recal_need_i` had at the previous rising clock edge.
- R3: A rising edge of `lock_req_i`, `unlock_req_i` or `recal_req_i` sets status bit 7, 8 or 9 respectively. A rising edge means the input is high at a clock edge and was low at the edge before. The bit is set from the next clock edge onward.
- R4: A write with `wr_sel_i`=0 clears each of status bits 7, 8 and 9 whose write-data bit is 1. Bits whose write-data bit is 0 are unchanged.
- R5: If a rising request edge and a clearing write to the same flag happen at the same clock edge, the flag ends up set.
- R6: A request held high sets its flag only once. If the flag is cleared while the request stays high, the flag stays clear.
- R7: All status bits other than 1, 2, 7, 8 and 9 read 0. Writes have no effect on status bits 1 and 2.
- R8: A write with `wr_sel_i`=1 loads enable bits 7, 8 and 9 from the write data. All other enable bits read 0.
- R9: `irq_o` is high exactly when some status bit among 7 to 9 and the enable bit at the same position are both 1. It changes in the same cycle as those registers.
- R10: After a clock edge with `rst_n` low, every status bit and enable bit is 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_req_i | input | 1 | Lock request sent to the PLL |
| unlock_req_i | input | 1 | Unlock request sent to the PLL |
| recal_req_i | input | 1 | Recalibration request sent to the PLL |
| lock_state_i | input | 1 | PLL lock indication (level) |
| recal_need_i | input | 1 | PLL needs recalibration (level) |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 1 | Write target: 0 status word, 1 enable word |
| wr_data_i | input | 32 | Write data |
| status_o | output | 32 | Status word: live bits 1 and 2, sticky flags 7 to 9 |
| enable_o | output | 32 | Enable word, bits 7 to 9 |
| irq_o | output | 1 | Combined interrupt |

## Verification
A flag that sets wrongly, clears wrongly or is lost shows up at `status_o` one clock edge after the stimulus that should have decided it. If the matching enable bit is set, it also shows up on `irq_o` in that same cycle. A stale edge-detector register shows up differently: either a held request sets its flag a second time after a clear, or a new pulse is missed. Either way the error is visible one edge after the request. The bench therefore compares every output against a model on every cycle, so any wrong internal state is reported within one cycle of the point where it first matters.

// File: rtl/pll_evt_pkg.sv
// Package: bit layout shared by the PLL event status block.
// Assumes a status/enable word of at least 10 bits.
package pll_evt_pkg;
    localparam int NUM_EVT   = 3;  // lock req, unlock req, recal req
    localparam int NUM_LIVE  = 2;  // lock state, recal needed
    localparam int LIVE_BASE = 1;  // live bits start at bit 1
    localparam int EVT_BASE  = 7;  // sticky flags start at bit 7

    // Bit position of sticky event flag i.
    function automatic int evt_pos(input int i);
        return EVT_BASE + i;
    endfunction

    // Bit position of live status bit i.
    function automatic int live_pos(input int i);
        return LIVE_BASE + i;
    endfunction
endpackage

// File: rtl/pll_evt_edge.sv
// Rising-edge detector for one request input.
// Assumes the input is synchronous to clk. The history register resets to 0.
module pll_evt_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic rise_o
);
    logic prev_q;

    // Remember the request level from the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= req_i;
    end

    assign rise_o = req_i & ~prev_q;

    AST_RISE_NOT_REPEATED: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);  // R6
endmodule

// File: rtl/pll_evt_flag.sv
// Sticky write-1-to-clear flag. A set takes priority over a clear in the same cycle.
// Assumes set_i and clr_i are single-cycle qualified strobes.
module pll_evt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Hold the flag until cleared. A new event beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

    AST_SET_STICKS:  assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);                  // R3
    AST_CLR_WORKS:   assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);     // R4
    AST_HOLD_SET:    assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);     // R4
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !set_i) |=> !flag_o);   // R3
endmodule

// File: rtl/pll_evt_live.sv
// Registers the live PLL health levels, one cycle of latency.
// Assumes the inputs are synchronous to clk.
module pll_evt_live #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] lvl_o
);
    // Sample the health levels every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_o <= '0;
        else        lvl_o <= lvl_i;
    end
endmodule

// File: rtl/pll_evt_irq.sv
// PLL event status block: live health bits, sticky request flags,
// an enable word and a combined interrupt.
// Assumes REG_W >= 10 and all inputs synchronous to clk.
module pll_evt_irq #(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_req_i,
    input  logic             unlock_req_i,
    input  logic             recal_req_i,
    input  logic             lock_state_i,
    input  logic             recal_need_i,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] status_o,
    output logic [REG_W-1:0] enable_o,
    output logic             irq_o
);
    import pll_evt_pkg::*;

    localparam int NE = NUM_EVT;
    localparam int NL = NUM_LIVE;

    logic [NE-1:0] req_vec;
    logic [NE-1:0] rise_vec;
    logic [NE-1:0] clr_vec;
    logic [NE-1:0] flag_vec;
    logic [NE-1:0] en_q;
    logic [NL-1:0] live_vec;
    logic          wr_stat;
    logic          wr_enab;

    assign req_vec = {recal_req_i, unlock_req_i, lock_req_i};
    assign wr_stat = wr_en_i & ~wr_sel_i;
    assign wr_enab = wr_en_i &  wr_sel_i;

    pll_evt_live #(.W(NL)) u_live (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i ({recal_need_i, lock_state_i}),
        .lvl_o (live_vec)
    );

    for (genvar i = 0; i < NE; i++) begin : g_evt
        assign clr_vec[i] = wr_stat & wr_data_i[evt_pos(i)];

        pll_evt_edge u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .req_i  (req_vec[i]),
            .rise_o (rise_vec[i])
        );

        pll_evt_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (rise_vec[i]),
            .clr_i  (clr_vec[i]),
            .flag_o (flag_vec[i])
        );

        // Load the enable bit for this event on an enable-word write.
        always_ff @(posedge clk) begin
            if (!rst_n)       en_q[i] <= 1'b0;
            else if (wr_enab) en_q[i] <= wr_data_i[evt_pos(i)];
        end
    end

    // Place live bits and flags into the status and enable words.
    always_comb begin
        status_o = '0;
        enable_o = '0;
        for (int k = 0; k < NL; k++) status_o[live_pos(k)] = live_vec[k];
        for (int k = 0; k < NE; k++) begin
            status_o[evt_pos(k)] = flag_vec[k];
            enable_o[evt_pos(k)] = en_q[k];
        end
    end

    assign irq_o = |(flag_vec & en_q);

    AST_LIVE_LOCK:  assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> status_o[live_pos(0)] == $past(lock_state_i));  // R1
    AST_LIVE_RECAL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> status_o[live_pos(1)] == $past(recal_need_i));  // R2
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (status_o & enable_o) != '0);                          // R9
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (status_o == '0 && enable_o == '0 && !irq_o));        // R10
endmodule

// File: tb/pll_evt_irq_bench.sv
module pll_evt_irq_bench;
    localparam int W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lock_req = 0, unlock_req = 0, recal_req = 0;
    logic lock_state = 0, recal_need = 0;
    logic wr_en = 0, wr_sel = 0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] status, enable;
    logic irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Reference state
    logic [2:0] m_flag = '0, m_en = '0, m_prev = '0;
    logic [1:0] m_live = '0;

    always #2.5 clk = ~clk;

    pll_evt_irq #(.REG_W(W)) u_pll_evt_irq (
        .clk(clk), .rst_n(rst_n),
        .lock_req_i(lock_req), .unlock_req_i(unlock_req), .recal_req_i(recal_req),
        .lock_state_i(lock_state), .recal_need_i(recal_need),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .status_o(status), .enable_o(enable), .irq_o(irq)
    );

    function automatic logic [W-1:0] exp_status();
        logic [W-1:0] s = '0;
        s[1] = m_live[0];
        s[2] = m_live[1];
        s[9:7] = m_flag;
        return s;
    endfunction

    function automatic logic [W-1:0] exp_enable();
        logic [W-1:0] e = '0;
        e[9:7] = m_en;
        return e;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Advance one edge with the inputs already driven; update the model; check.
    task automatic step();
        logic [2:0] req, rise, clr, nflag;
        req   = {recal_req, unlock_req, lock_req};
        rise  = req & ~m_prev;
        clr   = (wr_en && !wr_sel) ? wr_data[9:7] : 3'b000;
        nflag = (m_flag & ~clr) | rise;
        @(posedge clk);
        if (!rst_n) begin
            m_flag = '0; m_en = '0; m_prev = '0; m_live = '0;
        end else begin
            m_flag = nflag;
            if (wr_en && wr_sel) m_en = wr_data[9:7];
            m_prev = req;
            m_live = {recal_need, lock_state};
        end
        @(negedge clk);
        chk("R1 R2 live bits", {30'b0, status[2:1]}, {30'b0, m_live[1], m_live[0]});
        chk("R3 R4 R5 R6 flags", {29'b0, status[9:7]}, {29'b0, m_flag});
        chk("R7 reserved status bits zero", status & ~32'h386, '0);
        chk("R8 enable word", enable, exp_enable());
        chk("R9 irq", {31'b0, irq}, {31'b0, |(m_flag & m_en)});
    endtask

    task automatic drive(input logic [2:0] req, input logic [1:0] lvl,
                         input logic we, input logic sel, input logic [W-1:0] d);
        {recal_req, unlock_req, lock_req} = req;
        {recal_need, lock_state} = lvl;
        wr_en = we; wr_sel = sel; wr_data = d;
        step();
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd1234);
        @(negedge clk);
        drive(3'b000, 2'b00, 0, 0, '0);
        drive(3'b000, 2'b00, 0, 0, '0);
        rst_n = 1'b1;
        // R10: state right after reset
        chk("R10 reset status", status, '0);
        chk("R10 reset enable", enable, '0);
        chk("R10 reset irq", {31'b0, irq}, '0);

        // R3: each event alone, then enable and see irq (R9)
        drive(3'b001, 2'b01, 0, 0, '0);
        drive(3'b000, 2'b11, 0, 0, '0);
        drive(3'b010, 2'b10, 1, 1, 32'h0000_0080);
        chk("R9 irq with lock flag enabled", {31'b0, irq}, 32'd1);
        drive(3'b100, 2'b00, 0, 0, '0);
        chk("R3 all three flags", {29'b0, status[9:7]}, 32'h7);

        // R4: clear only bit 8
        drive(3'b000, 2'b00, 1, 0, 32'h0000_0100);
        chk("R4 selective clear", {29'b0, status[9:7]}, 32'h5);

        // R5: event and clear together on bit 8
        drive(3'b010, 2'b00, 1, 0, 32'h0000_0100);
        chk("R5 set beats clear", {31'b0, status[8]}, 32'd1);

        // R6: hold recal request high, clear, must stay clear
        drive(3'b100, 2'b00, 1, 0, 32'h0000_0380);
        drive(3'b100, 2'b00, 0, 0, '0);
        drive(3'b100, 2'b00, 1, 0, 32'h0000_0200);
        drive(3'b100, 2'b00, 0, 0, '0);
        drive(3'b100, 2'b00, 0, 0, '0);
        chk("R6 held level no re-set", {31'b0, status[9]}, '0);
        drive(3'b000, 2'b00, 0, 0, '0);

        // R7: write ones everywhere to status; live bits unaffected
        drive(3'b000, 2'b11, 0, 0, '0);
        drive(3'b000, 2'b11, 1, 0, 32'hFFFF_FFFF);
        chk("R7 live bits survive write", {30'b0, status[2:1]}, 32'h3);
        // R8: write all ones to enable, only 7..9 stick
        drive(3'b000, 2'b00, 1, 1, 32'hFFFF_FFFF);
        chk("R8 enable mask", enable, 32'h0000_0380);

        // Random traffic
        for (int n = 0; n < 600; n++) begin
            logic [W-1:0] d;
            d = $urandom;
            drive(3'($urandom), 2'($urandom), ($urandom % 4) == 0, 1'($urandom), d);
        end

        // R10: reset mid-run clears everything
        rst_n = 1'b0;
        drive(3'b111, 2'b11, 1, 1, 32'hFFFF_FFFF);
        rst_n = 1'b1;
        drive(3'b000, 2'b00, 0, 0, '0);
        chk("R10 reset enable again", enable, '0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5 * 50000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule